// File: doc/BRIEF.md
# Serial NAND Feature-Register Engine

This block is a small command engine that talks to a serial NAND flash over a single-lane SPI link. The host gives it one of three requests: read a feature register, write a feature register, or wait until the device is no longer busy. The engine builds each 24-bit SPI frame itself and holds chip select low for the whole frame. A frame is an opcode byte, a register address byte, and then either a data byte or a dummy byte. When the operation ends, the engine returns the byte it clocked in during the last byte of the frame. It also decodes that byte into the status flags and reports whether a wait ran out of time.

A wait request polls the status register at address 0xC0 again and again while its busy bit is set. It stops with success as soon as the busy bit reads clear. It stops with a timeout once the elapsed time reaches the limit given with the request, counted in milliseconds. Typical limits are 2 ms for a page read or page program, 15 ms for a block erase and 500 ms for a device reset. A prescaler parameter derives the millisecond timebase from the system clock. The SPI clock speed comes from a divider input that is sampled when a request is accepted.

Top module: `spi_nand_poller`

## Requirements
- R1: A read request (req_op 2'b00) sends one frame: 0x05, the register address, then 0x00, in SPI mode 0 with the MSB first. The byte sampled during the third byte is returned on rd_data.
- R2: A write request (req_op 2'b01) sends 0x01, the register address, then req_wdata, all within one chip-select-low period. rd_data returns the byte sampled during the third byte.
- R3: A wait request (req_op[1]=1) repeats the frame 0x05, 0xC0, 0x00 while bit 0 of the returned byte is 1. It completes with timed_out=0 on the first frame whose bit 0 is 0, and rd_data then holds that byte.
- R4: If bit 0 is still 1 at the end of a poll, and at least req_limit_ms milliseconds (TICKS_PER_MS clocks each) have passed since the request, the wait completes with timed_out=1. rd_data then holds the last status. At least one poll is always made, even when the limit is 0.
- R5: The flag outputs decode rd_data as follows: st_busy=bit 0, st_wel=bit 1, st_erase_fail=bit 2, st_prog_fail=bit 3, st_ecc=bits 5:4, st_bbt_full=bit 6.
- R6: Each SCLK half period lasts clk_div+1 clocks. SCLK is low whenever chip select is high. Chip select stays high for at least 2*(clk_div+1) clocks between frames.
- R7: A request is accepted only while ready=1. A request raised while ready=0 produces no frame and no done.
- R8: Each operation ends with exactly one done pulse lasting one cycle. Results hold until the next done. timed_out is 0 for read and write requests.
- R9: After reset, cs_n=1, sclk=0, ready=1, done=0, rd_data=0 and timed_out=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when ready is high |
| req_op | input | 2 | 00 read, 01 write, 1x wait until ready |
| req_reg | input | 8 | Feature register address for read or write |
| req_wdata | input | 8 | Data byte for a write |
| req_limit_ms | input | LIM_W | Timeout for a wait, in milliseconds |
| clk_div | input | DIV_W | SCLK half period minus one, in clocks |
| ready | output | 1 | Engine idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte sampled in the third frame byte |
| timed_out | output | 1 | Wait ended on the time limit |
| st_busy | output | 1 | Decoded busy flag |
| st_wel | output | 1 | Decoded write-enable latch |
| st_erase_fail | output | 1 | Decoded erase failure |
| st_prog_fail | output | 1 | Decoded program failure |
| st_ecc | output | 2 | Decoded ECC result code |
| st_bbt_full | output | 1 | Decoded remap-table-full flag |
| spi_sclk | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
A corrupted shift register or bit counter shows up within one frame. The flash model then captures a wrong opcode, a wrong address or the wrong number of bits, and it sees this when chip select rises. A wrong decision in the poll loop shows up at the done pulse. It appears as an extra or missing status frame, a timed_out value that disagrees with the final busy bit, or a completion time outside the window set by the millisecond limit. A fault in the divider or the gap counter is caught on the very next SCLK edge or chip-select fall, because the half-period length and the gap length are checked there.

// File: rtl/spi_nand_poller.sv
module spi_nand_poller #(
  parameter int TICKS_PER_MS = 125000,
  parameter int DIV_W        = 8,
  parameter int LIM_W        = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_op,
  input  logic [7:0]       req_reg,
  input  logic [7:0]       req_wdata,
  input  logic [LIM_W-1:0] req_limit_ms,
  input  logic [DIV_W-1:0] clk_div,
  output logic             ready,
  output logic             done,
  output logic [7:0]       rd_data,
  output logic             timed_out,
  output logic             st_busy,
  output logic             st_wel,
  output logic             st_erase_fail,
  output logic             st_prog_fail,
  output logic [1:0]       st_ecc,
  output logic             st_bbt_full,
  output logic             spi_sclk,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int PRE_W = (TICKS_PER_MS > 2) ? $clog2(TICKS_PER_MS) : 1;
  localparam logic [23:0] POLL_FRAME = {8'h05, 8'hC0, 8'h00};

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_SHIFT, S_FIN} state_t;

  state_t           state;
  logic [23:0]      tx;
  logic [7:0]       rx;
  logic [4:0]       bitcnt;
  logic [DIV_W-1:0] div_q, dcnt;
  logic [DIV_W:0]   gcnt;
  logic             op_wait;
  logic [LIM_W-1:0] limit_q, ms;
  logic [PRE_W-1:0] pre;

  assign ready         = (state == S_IDLE);
  assign spi_mosi      = tx[23];
  assign st_busy       = rd_data[0];
  assign st_wel        = rd_data[1];
  assign st_erase_fail = rd_data[2];
  assign st_prog_fail  = rd_data[3];
  assign st_ecc        = rd_data[5:4];
  assign st_bbt_full   = rd_data[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      ms  <= '0;
    end else if (state == S_IDLE) begin
      pre <= '0;
      ms  <= '0;
    end else if (pre == PRE_W'(TICKS_PER_MS - 1)) begin
      pre <= '0;
      if (ms != '1) ms <= ms + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tx        <= '0;
      rx        <= '0;
      bitcnt    <= '0;
      div_q     <= '0;
      dcnt      <= '0;
      gcnt      <= '0;
      op_wait   <= 1'b0;
      limit_q   <= '0;
      done      <= 1'b0;
      rd_data   <= '0;
      timed_out <= 1'b0;
      spi_sclk  <= 1'b0;
      spi_cs_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_wait <= req_op[1];
          if (req_op[1])      tx <= POLL_FRAME;
          else if (req_op[0]) tx <= {8'h01, req_reg, req_wdata};
          else                tx <= {8'h05, req_reg, 8'h00};
          div_q   <= clk_div;
          limit_q <= req_limit_ms;
          gcnt    <= '0;
          state   <= S_GAP;
        end
        S_GAP: begin
          if (gcnt == {div_q, 1'b1}) begin
            gcnt     <= '0;
            dcnt     <= '0;
            bitcnt   <= '0;
            spi_cs_n <= 1'b0;
            state    <= S_SHIFT;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_SHIFT: begin
          if (dcnt == div_q) begin
            dcnt <= '0;
            if (!spi_sclk) begin
              spi_sclk <= 1'b1;
              rx       <= {rx[6:0], spi_miso};
            end else begin
              spi_sclk <= 1'b0;
              if (bitcnt == 5'd23) begin
                spi_cs_n <= 1'b1;
                state    <= S_FIN;
              end else begin
                bitcnt <= bitcnt + 1'b1;
                tx     <= {tx[22:0], 1'b0};
              end
            end
          end else begin
            dcnt <= dcnt + 1'b1;
          end
        end
        default: begin
          if (!op_wait || !rx[0] || ms >= limit_q) begin
            done      <= 1'b1;
            rd_data   <= rx;
            timed_out <= op_wait && rx[0];
            if (op_wait && !rx[0]) limit_q <= '0;
            state     <= S_IDLE;
          end else begin
            tx    <= POLL_FRAME;
            gcnt  <= '0;
            state <= S_GAP;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_nand_poller_chk.sv
module spi_nand_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic       done,
  input logic       ready,
  input logic       req_valid,
  input logic       timed_out,
  input logic       op_wait,
  input logic [7:0] rd_data
);
  // R6
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> ready);
  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && ready) |=> !ready);
  // R4
  timeout_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && timed_out) |-> (op_wait && rd_data[0]));
  // R3
  wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && op_wait && !timed_out) |-> !rd_data[0]);
endmodule

bind spi_nand_poller spi_nand_poller_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .done(done),
  .ready(ready), .req_valid(req_valid), .timed_out(timed_out),
  .op_wait(op_wait), .rd_data(rd_data)
);

// File: tb/tb_spi_nand_poller.sv
module tb_spi_nand_poller;
  localparam int T_MS = 200;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [7:0] req_reg = 8'h00, req_wdata = 8'h00, req_limit_ms = 8'h00;
  logic [7:0] clk_div = 8'd1;
  logic ready, done, timed_out, st_busy, st_wel, st_erase_fail, st_prog_fail, st_bbt_full;
  logic [1:0] st_ecc;
  logic [7:0] rd_data;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  spi_nand_poller #(.TICKS_PER_MS(T_MS), .DIV_W(8), .LIM_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_reg(req_reg),
    .req_wdata(req_wdata), .req_limit_ms(req_limit_ms), .clk_div(clk_div), .ready(ready),
    .done(done), .rd_data(rd_data), .timed_out(timed_out), .st_busy(st_busy), .st_wel(st_wel),
    .st_erase_fail(st_erase_fail), .st_prog_fail(st_prog_fail), .st_ecc(st_ecc),
    .st_bbt_full(st_bbt_full), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  typedef struct { logic [7:0] rd; logic to; } exp_t;
  exp_t exp_q[$];
  logic [23:0] exp_frame;
  int frames = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] r_prot = 8'h00, r_conf = 8'h00, r_stat = 8'h00;
  int busy_polls = 0;
  bit busy_forever = 0;
  logic [23:0] sr = '0;
  logic [7:0] resp = '0;
  int bc = 0;

  always @(negedge spi_cs_n) begin bc = 0; sr = '0; end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    sr = {sr[22:0], spi_mosi};
    bc++;
    if (bc == 16) begin
      resp = 8'h00;
      if (sr[15:8] == 8'h05) begin
        case (sr[7:0])
          8'hA0: resp = r_prot;
          8'hB0: resp = r_conf;
          8'hC0: begin
            resp = r_stat | ((busy_forever || busy_polls > 0) ? 8'h01 : 8'h00);
            if (busy_polls > 0) busy_polls--;
          end
          default: resp = 8'h00;
        endcase
      end
    end
  end
  always @(negedge spi_sclk) if (!spi_cs_n && bc >= 16 && bc < 24) spi_miso = resp[23-bc];
  always @(posedge spi_cs_n) if (rst_n) begin
    frames++;
    check(bc == 24, "R1 frame length", bc, 24);
    check(sr == exp_frame, "R1 R2 R3 frame content", sr, exp_frame);
    if (sr[23:16] == 8'h01) begin
      if (sr[15:8] == 8'hA0) r_prot = sr[7:0];
      if (sr[15:8] == 8'hB0) r_conf = sr[7:0];
    end
  end

  int gap = 0, hi = 0;
  logic prev_done = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (spi_cs_n) begin
      gap++;
      if (spi_sclk) check(0, "R6 sclk high while deselected", 1, 0);
    end else if (gap != 0) begin
      check(gap >= 2 * (clk_div + 1), "R6 select gap", gap, 2 * (clk_div + 1));
      gap = 0;
    end
    if (spi_sclk) hi++;
    else if (hi != 0) begin
      check(hi == clk_div + 1, "R6 half period", hi, clk_div + 1);
      hi = 0;
    end
    if (done && prev_done) check(0, "R8 done longer than one cycle", 1, 0);
    prev_done = done;
    if (done) begin
      if (exp_q.size() == 0) check(0, "R7 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = exp_q.pop_front();
        check(rd_data == e.rd, "R1 R2 R3 rd_data", rd_data, e.rd);
        check(timed_out == e.to, "R4 R8 timed_out", timed_out, e.to);
        check({st_bbt_full, st_ecc, st_prog_fail, st_erase_fail, st_wel, st_busy} == e.rd[6:0],
              "R5 flag decode", {st_bbt_full, st_ecc, st_prog_fail, st_erase_fail, st_wel, st_busy}, e.rd[6:0]);
      end
    end
  end

  longint t0, t1;
  task automatic run_op(input logic [1:0] op, input logic [7:0] rg, input logic [7:0] wd,
                        input logic [7:0] lim, input logic [7:0] erd, input bit eto,
                        input logic [23:0] frm, input int efr);
    exp_t e;
    @(negedge clk);
    while (!ready) @(negedge clk);
    e.rd = erd; e.to = eto;
    exp_q.push_back(e);
    exp_frame = frm;
    frames = 0;
    req_op = op; req_reg = rg; req_wdata = wd; req_limit_ms = lim; req_valid = 1'b1;
    t0 = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    t1 = cyc;
    if (efr > 0) check(frames == efr, "R3 R7 frame count", frames, efr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "R8 watchdog: operation never completed", 0, 1);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R9 ready", ready, 1);
    check(spi_cs_n == 1'b1, "R9 cs_n", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R9 sclk", spi_sclk, 0);
    check(done == 1'b0, "R9 done", done, 0);
    check(rd_data == 8'h00, "R9 rd_data", rd_data, 0);
    check(timed_out == 1'b0, "R9 timed_out", timed_out, 0);

    clk_div = 8'd1;
    run_op(2'b01, 8'hA0, 8'h3C, 8'd0, 8'h00, 1'b0, 24'h01A03C, 1);   // R2
    run_op(2'b00, 8'hA0, 8'h00, 8'd0, 8'h3C, 1'b0, 24'h05A000, 1);   // R1
    clk_div = 8'd0;
    run_op(2'b01, 8'hB0, 8'h18, 8'd0, 8'h00, 1'b0, 24'h01B018, 1);   // R2
    run_op(2'b00, 8'hB0, 8'h00, 8'd0, 8'h18, 1'b0, 24'h05B000, 1);   // R1
    clk_div = 8'd3;
    run_op(2'b00, 8'hA0, 8'h00, 8'd0, 8'h3C, 1'b0, 24'h05A000, 1);   // R1, R6 slow clock

    clk_div = 8'd1;
    r_stat = 8'h7E; busy_polls = 0;
    run_op(2'b10, 8'h00, 8'h00, 8'd2, 8'h7E, 1'b0, 24'h05C000, 1);   // R3 R5
    r_stat = 8'h02; busy_polls = 3;
    run_op(2'b11, 8'h00, 8'h00, 8'd5, 8'h02, 1'b0, 24'h05C000, 4);   // R3 repeated polls

    busy_forever = 1;
    run_op(2'b10, 8'h00, 8'h00, 8'd2, 8'h03, 1'b1, 24'h05C000, 0);   // R4
    check((t1 - t0) >= 2 * T_MS, "R4 timeout not early", t1 - t0, 2 * T_MS);
    check((t1 - t0) <= 2 * T_MS + 2 * (50 * 2 + 4), "R4 timeout not late", t1 - t0, 2 * T_MS + 208);
    run_op(2'b10, 8'h00, 8'h00, 8'd0, 8'h03, 1'b1, 24'h05C000, 1);   // R4 zero limit single poll
    busy_forever = 0;
    r_stat = 8'h35;
    run_op(2'b00, 8'hC0, 8'h00, 8'd0, 8'h35, 1'b0, 24'h05C000, 1);   // R5 R8 read of status

    fork
      run_op(2'b00, 8'hA0, 8'h00, 8'd0, 8'h3C, 1'b0, 24'h05A000, 1); // R7
      begin
        repeat (20) @(negedge clk);
        req_op = 2'b01; req_reg = 8'hA0; req_wdata = 8'hFF; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
      end
    join
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7 no extra done pending", exp_q.size(), 0);
    run_op(2'b00, 8'hA0, 8'h00, 8'd0, 8'h3C, 1'b0, 24'h05A000, 1);   // R7 ignored write left A0

    repeat (20) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule